// File: doc/BRIEF.md
# Pixel Defect Grader

The block screens a raster stream of digitised sensor samples and grades each frame against two defect classes. Every sample comes with a neighbour reference, which an upstream stage has already computed, and a bit that selects the test mode: dark (no light) or illuminated. The block compares each sample with its reference and flags it when it falls outside the mode's limits. It keeps a small saturating tally of flagged samples for every column.

Alongside the sample stream, an upstream column averager delivers one statistic per column: the column mean and the mean of its neighbours. The block uses it to mark columns with an offset and, in dark mode, saturated columns. A column is also marked when its flagged-sample tally passes the promotion count.

After the last sample of a frame, the block stalls its input and sweeps the column store once. The sweep counts defective and saturated columns and detects two defective columns that sit side by side. It then combines these with the frame's point total and an external cluster count into a class-1 and a class-2 verdict. The verdict and the totals are held until the next frame starts.

Top module: `defect_classifier`

## Requirements
- R1: In dark mode (`pix_illum`=0) a sample is flagged exactly when `pix_value` exceeds `pix_ref + thr_dark_pt`. A sample below its reference is never flagged in this mode.
- R2: In illuminated mode (`pix_illum`=1) a sample is flagged exactly when value*100 > ref*107 or value*100 < ref*89.
- R3: One cycle after each accepted sample, `flag_valid` is 1 and `flag_col` equals that sample's column. `flag_defect` carries the R1/R2 result.
- R4: Each column's tally counts flagged in-frame samples and saturates at PROMOTE+1, which is 11 by default. A column whose tally reaches PROMOTE+1 is a defective column, so 10 flagged samples in a column do not make it defective.
- R5: A column statistic marks its column as defective under either of two conditions. In dark mode, |avg − nbr| > `thr_dark_col`. In illuminated mode, avg*1000 > nbr*1015 or avg*1000 < nbr*985.
- R6: A dark-mode statistic with avg − nbr > `thr_sat_col` marks the column as saturated and as defective. It is counted in `res_saturated`, and any saturated column clears both `res_pass1` and `res_pass2`.
- R7: Two defective columns with adjacent indices set `res_adjacent` and clear both passes.
- R8: `res_pass1` requires all of the following:
  - points ≤ PT_LIMIT (default 2000)
  - `ext_clusters` ≤ CL_LIMIT (default 40)
  - defective columns ≤ C1_COLS (default 0)
  - no saturated column
  - no adjacency

  `res_pass1` implies `res_pass2`.
- R9: `res_pass2` uses the same conditions as R8, except that the column limit is C2_COLS (default 15).
- R10: Accepting a sample with `pix_sof`=1 clears all tallies and totals. Results stay valid and unchanged from the end of grading until a start-of-frame sample is accepted. Samples outside a frame (no `pix_sof` while idle or done) change no result.
- R11: `pix_ready` is low only during the end-of-frame sweep. A sample offered then is held and accepted later without loss.
- R12: A column statistic is taken only during a frame, including the start-of-frame cycle. One offered during the sweep has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Sample offered |
| pix_ready | output | 1 | Sample accepted when high with pix_valid |
| pix_sof | input | 1 | First sample of a frame |
| pix_eof | input | 1 | Last sample of a frame |
| pix_col | input | CW | Column index of the sample |
| pix_illum | input | 1 | 1 = illuminated test, 0 = dark test |
| pix_value | input | DW | Sample code |
| pix_ref | input | DW | Neighbour reference code |
| cst_valid | input | 1 | Column statistic present |
| cst_col | input | CW | Column of the statistic |
| cst_illum | input | 1 | Mode of the statistic |
| cst_avg | input | DW | Column mean |
| cst_nbr | input | DW | Neighbour column mean |
| thr_dark_pt | input | DW | Dark point threshold code |
| thr_dark_col | input | DW | Dark column offset threshold code |
| thr_sat_col | input | DW | Saturated column threshold code |
| ext_clusters | input | CLW | Cluster count from an external labeller |
| flag_valid | output | 1 | Per-sample flag present |
| flag_defect | output | 1 | Sample is a point defect |
| flag_col | output | CW | Column of the flagged sample |
| res_valid | output | 1 | Frame results valid |
| res_pass1 | output | 1 | Frame meets class 1 |
| res_pass2 | output | 1 | Frame meets class 2 |
| res_points | output | PTW | Point defects in the frame |
| res_columns | output | NCW | Defective columns |
| res_saturated | output | NCW | Saturated columns |
| res_adjacent | output | 1 | Adjacent defective columns found |

## Verification
The assertions watch properties that must hold on every cycle:
- the per-column tally never passes its saturation value;
- a class-1 pass never appears without a class-2 pass;
- a saturated column or an adjacent pair always blocks both passes;
- held results never move before a new frame starts.

Only the bench scenarios can show whether the thresholds sit exactly on the right code, whether the tenth versus the eleventh flagged sample promotes a column, whether the column and point limits fall at the correct counts, and whether a sample stalled during the sweep or a stray column statistic is handled correctly.

// File: rtl/defect_pkg.sv
package defect_pkg;
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_RUN   = 2'd1,
    GS_GRADE = 2'd2,
    GS_DONE  = 2'd3
  } grade_state_e;
endpackage

// File: rtl/defect_pixel_cmp.sv
module defect_pixel_cmp #(
  parameter int DW = 12
) (
  input  logic          illum,
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] refv,
  input  logic [DW-1:0] thr,
  output logic          defect
);
  localparam int MW = DW + 7;

  logic [DW:0]   dark_lim;
  logic [MW-1:0] v_scaled, r_hi, r_lo;

  always_comb begin
    dark_lim = {1'b0, refv} + {1'b0, thr};
    v_scaled = MW'(value) * MW'(100);
    r_hi     = MW'(refv) * MW'(107);
    r_lo     = MW'(refv) * MW'(89);
    if (illum) defect = (v_scaled > r_hi) || (v_scaled < r_lo);
    else       defect = ({1'b0, value} > dark_lim);
  end
endmodule

// File: rtl/defect_col_cmp.sv
module defect_col_cmp #(
  parameter int DW = 12
) (
  input  logic          illum,
  input  logic [DW-1:0] avg,
  input  logic [DW-1:0] nbr,
  input  logic [DW-1:0] thr_col,
  input  logic [DW-1:0] thr_sat,
  output logic          offs,
  output logic          sat
);
  localparam int MW = DW + 10;

  logic [DW-1:0] diff;
  logic [DW:0]   sat_lim;
  logic [MW-1:0] a_scaled, n_hi, n_lo;

  always_comb begin
    diff     = (avg > nbr) ? (avg - nbr) : (nbr - avg);
    sat_lim  = {1'b0, nbr} + {1'b0, thr_sat};
    a_scaled = MW'(avg) * MW'(1000);
    n_hi     = MW'(nbr) * MW'(1015);
    n_lo     = MW'(nbr) * MW'(985);
    if (illum) begin
      offs = (a_scaled > n_hi) || (a_scaled < n_lo);
      sat  = 1'b0;
    end else begin
      offs = (diff > thr_col);
      sat  = ({1'b0, avg} > sat_lim);
    end
  end
endmodule

// File: rtl/defect_col_store.sv
module defect_col_store #(
  parameter int NCOL    = 32,
  parameter int CW      = 5,
  parameter int CNT_W   = 4,
  parameter int CNT_MAX = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pt_inc,
  input  logic [CW-1:0]    pt_col,
  input  logic             cs_we,
  input  logic [CW-1:0]    cs_col,
  input  logic             cs_offs,
  input  logic             cs_sat,
  input  logic [CW-1:0]    rd_col,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_offs,
  output logic             rd_sat
);
  logic [CNT_W-1:0] cnt_all  [NCOL];
  logic             offs_all [NCOL];
  logic             sat_all  [NCOL];

  for (genvar g = 0; g < NCOL; g++) begin : g_col
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             offs_q, offs_d, sat_q, sat_d;
    logic             hit_pt, hit_cs, en;

    always_comb begin
      hit_pt = pt_inc && (pt_col == CW'(g));
      hit_cs = cs_we  && (cs_col == CW'(g));
      en     = clr || hit_pt || hit_cs;
      cnt_d  = clr ? '0 : cnt_q;
      if (hit_pt && (cnt_d != CNT_W'(CNT_MAX))) cnt_d = cnt_d + 1'b1;
      offs_d = (!clr && offs_q) || (hit_cs && cs_offs);
      sat_d  = (!clr && sat_q)  || (hit_cs && cs_sat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        offs_q <= 1'b0;
        sat_q  <= 1'b0;
      end else if (en) begin
        cnt_q  <= cnt_d;
        offs_q <= offs_d;
        sat_q  <= sat_d;
      end
    end

    assign cnt_all[g]  = cnt_q;
    assign offs_all[g] = offs_q;
    assign sat_all[g]  = sat_q;

    assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(CNT_MAX))
      else $error("column tally above saturation");
  end

  assign rd_cnt  = cnt_all[rd_col];
  assign rd_offs = offs_all[rd_col];
  assign rd_sat  = sat_all[rd_col];
endmodule

// File: rtl/defect_grader.sv
module defect_grader
  import defect_pkg::*;
#(
  parameter int NCOL     = 32,
  parameter int CW       = 5,
  parameter int CNT_W    = 4,
  parameter int CNT_MAX  = 11,
  parameter int PTW      = 16,
  parameter int NCW      = 6,
  parameter int CLW      = 8,
  parameter int PT_LIMIT = 2000,
  parameter int CL_LIMIT = 40,
  parameter int C1_COLS  = 0,
  parameter int C2_COLS  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_acc,
  input  logic             pix_sof,
  input  logic             pix_eof,
  input  logic             pix_defect,
  input  logic [CLW-1:0]   ext_clusters,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic             rd_offs,
  input  logic             rd_sat,
  output logic             busy,
  output logic             cs_open,
  output logic             clr,
  output logic             pt_inc,
  output logic [CW-1:0]    sweep_col,
  output logic             res_valid,
  output logic             res_pass1,
  output logic             res_pass2,
  output logic [PTW-1:0]   res_points,
  output logic [NCW-1:0]   res_columns,
  output logic [NCW-1:0]   res_saturated,
  output logic             res_adjacent
);
  grade_state_e   st_q, st_d;
  logic [CW-1:0]  idx_q, idx_d;
  logic           prev_q, prev_d, adj_q, adj_d;
  logic [NCW-1:0] cols_q, cols_d, satc_q, satc_d;
  logic [PTW-1:0] pts_q, pts_d, pt_base;
  logic           frm_pix, go_grade, last, res_en;
  logic           cur_def, adj_nx, p1_d, p2_d, common_ok;
  logic [NCW-1:0] cols_nx, sat_nx;

  // frame-level strobes for the column store
  always_comb begin
    frm_pix = pix_acc && (pix_sof || (st_q == GS_RUN));
    clr     = pix_acc && pix_sof;
    pt_inc  = frm_pix && pix_defect;
    cs_open = (st_q == GS_RUN) || clr;
    busy    = (st_q == GS_GRADE);
    go_grade = frm_pix && pix_eof;
    last    = (idx_q == CW'(NCOL - 1));
  end

  // sweep arithmetic on the column being read
  always_comb begin
    cur_def   = (rd_cnt == CNT_W'(CNT_MAX)) || rd_offs || rd_sat;
    cols_nx   = cols_q + NCW'(cur_def);
    sat_nx    = satc_q + NCW'(rd_sat);
    adj_nx    = adj_q || (cur_def && prev_q);
    common_ok = (pts_q <= PTW'(PT_LIMIT)) && (ext_clusters <= CLW'(CL_LIMIT)) &&
                (sat_nx == '0) && !adj_nx;
    p1_d      = common_ok && (cols_nx <= NCW'(C1_COLS));
    p2_d      = common_ok && (cols_nx <= NCW'(C2_COLS));
  end

  // next-state
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    prev_d  = prev_q;
    cols_d  = cols_q;
    satc_d  = satc_q;
    adj_d   = adj_q;
    res_en  = 1'b0;
    pt_base = pix_sof ? '0 : pts_q;
    pts_d   = pts_q;
    if (frm_pix) pts_d = pt_base + PTW'(pix_defect && (pt_base != '1));
    if (go_grade) begin
      st_d   = GS_GRADE;
      idx_d  = '0;
      prev_d = 1'b0;
      cols_d = '0;
      satc_d = '0;
      adj_d  = 1'b0;
    end else begin
      case (st_q)
        GS_IDLE, GS_DONE: if (frm_pix) st_d = GS_RUN;
        GS_GRADE: begin
          idx_d  = idx_q + 1'b1;
          prev_d = cur_def;
          cols_d = cols_nx;
          satc_d = sat_nx;
          adj_d  = adj_nx;
          if (last) begin
            st_d   = GS_DONE;
            res_en = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GS_IDLE;
      idx_q  <= '0;
      prev_q <= 1'b0;
      cols_q <= '0;
      satc_q <= '0;
      adj_q  <= 1'b0;
      pts_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      prev_q <= prev_d;
      cols_q <= cols_d;
      satc_q <= satc_d;
      adj_q  <= adj_d;
      pts_q  <= pts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_pass1     <= 1'b0;
      res_pass2     <= 1'b0;
      res_points    <= '0;
      res_columns   <= '0;
      res_saturated <= '0;
      res_adjacent  <= 1'b0;
    end else if (res_en) begin
      res_pass1     <= p1_d;
      res_pass2     <= p2_d;
      res_points    <= pts_q;
      res_columns   <= cols_nx;
      res_saturated <= sat_nx;
      res_adjacent  <= adj_nx;
    end
  end

  assign sweep_col = idx_q;
  assign res_valid = (st_q == GS_DONE);

  assert_class_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass1) |-> res_pass2)
    else $error("class 1 pass without class 2 pass");

  assert_sat_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_saturated != '0)) |-> (!res_pass1 && !res_pass2))
    else $error("saturated column did not fail the frame");

  assert_adjacent_fails_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_adjacent) |-> (!res_pass1 && !res_pass2))
    else $error("adjacent columns did not fail the frame");

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !(pix_acc && pix_sof)) |=>
      (res_valid && $stable(res_points) && $stable(res_columns) &&
       $stable(res_pass1) && $stable(res_pass2)))
    else $error("results moved before a new frame");
endmodule

// File: rtl/defect_classifier.sv
module defect_classifier #(
  parameter int DW       = 12,
  parameter int NCOL     = 32,
  parameter int CLW      = 8,
  parameter int PTW      = 16,
  parameter int PROMOTE  = 10,
  parameter int PT_LIMIT = 2000,
  parameter int CL_LIMIT = 40,
  parameter int C1_COLS  = 0,
  parameter int C2_COLS  = 15,
  localparam int CW      = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int NCW     = $clog2(NCOL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_valid,
  output logic           pix_ready,
  input  logic           pix_sof,
  input  logic           pix_eof,
  input  logic [CW-1:0]  pix_col,
  input  logic           pix_illum,
  input  logic [DW-1:0]  pix_value,
  input  logic [DW-1:0]  pix_ref,
  input  logic           cst_valid,
  input  logic [CW-1:0]  cst_col,
  input  logic           cst_illum,
  input  logic [DW-1:0]  cst_avg,
  input  logic [DW-1:0]  cst_nbr,
  input  logic [DW-1:0]  thr_dark_pt,
  input  logic [DW-1:0]  thr_dark_col,
  input  logic [DW-1:0]  thr_sat_col,
  input  logic [CLW-1:0] ext_clusters,
  output logic           flag_valid,
  output logic           flag_defect,
  output logic [CW-1:0]  flag_col,
  output logic           res_valid,
  output logic           res_pass1,
  output logic           res_pass2,
  output logic [PTW-1:0] res_points,
  output logic [NCW-1:0] res_columns,
  output logic [NCW-1:0] res_saturated,
  output logic           res_adjacent
);
  localparam int CNT_MAX = PROMOTE + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             pix_acc, pix_def, cs_offs, cs_sat;
  logic             busy, cs_open, clr, pt_inc, cs_we;
  logic [CW-1:0]    sweep_col;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_offs, rd_sat;
  logic             fv_d, fd_d;
  logic [CW-1:0]    fc_d;

  assign pix_ready = !busy;
  assign pix_acc   = pix_valid && pix_ready;
  assign cs_we     = cst_valid && cs_open;

  defect_pixel_cmp #(.DW(DW)) u_pix_cmp (
    .illum(pix_illum), .value(pix_value), .refv(pix_ref),
    .thr(thr_dark_pt), .defect(pix_def)
  );

  defect_col_cmp #(.DW(DW)) u_col_cmp (
    .illum(cst_illum), .avg(cst_avg), .nbr(cst_nbr),
    .thr_col(thr_dark_col), .thr_sat(thr_sat_col),
    .offs(cs_offs), .sat(cs_sat)
  );

  defect_col_store #(
    .NCOL(NCOL), .CW(CW), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .pt_inc(pt_inc), .pt_col(pix_col),
    .cs_we(cs_we), .cs_col(cst_col), .cs_offs(cs_offs), .cs_sat(cs_sat),
    .rd_col(sweep_col), .rd_cnt(rd_cnt), .rd_offs(rd_offs), .rd_sat(rd_sat)
  );

  defect_grader #(
    .NCOL(NCOL), .CW(CW), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .PTW(PTW),
    .NCW(NCW), .CLW(CLW), .PT_LIMIT(PT_LIMIT), .CL_LIMIT(CL_LIMIT),
    .C1_COLS(C1_COLS), .C2_COLS(C2_COLS)
  ) u_grader (
    .clk(clk), .rst_n(rst_n),
    .pix_acc(pix_acc), .pix_sof(pix_sof), .pix_eof(pix_eof),
    .pix_defect(pix_def), .ext_clusters(ext_clusters),
    .rd_cnt(rd_cnt), .rd_offs(rd_offs), .rd_sat(rd_sat),
    .busy(busy), .cs_open(cs_open), .clr(clr), .pt_inc(pt_inc),
    .sweep_col(sweep_col),
    .res_valid(res_valid), .res_pass1(res_pass1), .res_pass2(res_pass2),
    .res_points(res_points), .res_columns(res_columns),
    .res_saturated(res_saturated), .res_adjacent(res_adjacent)
  );

  // per-sample flag register
  always_comb begin
    fv_d = pix_acc;
    fd_d = pix_acc ? pix_def : flag_defect;
    fc_d = pix_acc ? pix_col : flag_col;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_valid  <= 1'b0;
      flag_defect <= 1'b0;
      flag_col    <= '0;
    end else begin
      flag_valid  <= fv_d;
      flag_defect <= fd_d;
      flag_col    <= fc_d;
    end
  end

  assert_no_accept_in_sweep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> !flag_valid)
    else $error("flag produced for a stalled sample");
endmodule

// File: tb/tb_defect_classifier.sv
`timescale 1ns/1ps
module tb_defect_classifier;
  localparam int DW = 12, NCOL = 32, CW = 5, NCW = 6, CLW = 8, PTW = 16;
  localparam int PTL = 100;
  localparam int TPT = 30, TCOL = 8, TSAT = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pix_valid, pix_ready, pix_sof, pix_eof, pix_illum;
  logic [CW-1:0] pix_col, cst_col, flag_col;
  logic [DW-1:0] pix_value, pix_ref, cst_avg, cst_nbr;
  logic cst_valid, cst_illum, flag_valid, flag_defect;
  logic [CLW-1:0] ext_clusters;
  logic res_valid, res_pass1, res_pass2, res_adjacent;
  logic [PTW-1:0] res_points;
  logic [NCW-1:0] res_columns, res_saturated;

  defect_classifier #(.DW(DW), .NCOL(NCOL), .CLW(CLW), .PTW(PTW), .PT_LIMIT(PTL)) dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_sof(pix_sof), .pix_eof(pix_eof), .pix_col(pix_col), .pix_illum(pix_illum),
    .pix_value(pix_value), .pix_ref(pix_ref), .cst_valid(cst_valid), .cst_col(cst_col),
    .cst_illum(cst_illum), .cst_avg(cst_avg), .cst_nbr(cst_nbr),
    .thr_dark_pt(DW'(TPT)), .thr_dark_col(DW'(TCOL)), .thr_sat_col(DW'(TSAT)),
    .ext_clusters(ext_clusters), .flag_valid(flag_valid), .flag_defect(flag_defect),
    .flag_col(flag_col), .res_valid(res_valid), .res_pass1(res_pass1),
    .res_pass2(res_pass2), .res_points(res_points), .res_columns(res_columns),
    .res_saturated(res_saturated), .res_adjacent(res_adjacent)
  );

  int n_tests = 0, n_fail = 0;
  int fv [16][NCOL];
  int fr [16][NCOL];
  bit fi [16][NCOL];
  int cavg [NCOL];
  int cnbr [NCOL];
  bit cill [NCOL];
  int e_pts, e_cols, e_sat;
  bit e_adj, e_p1, e_p2, saw_stall;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit pt_def(int v, int r, bit ill);
    if (ill) return (v * 100 > r * 107) || (v * 100 < r * 89);
    return v > r + TPT;
  endfunction

  function automatic bit c_offs(int a, int n, bit ill);
    int d;
    if (ill) return (a * 1000 > n * 1015) || (a * 1000 < n * 985);
    d = (a > n) ? a - n : n - a;
    return d > TCOL;
  endfunction

  function automatic bit c_sat(int a, int n, bit ill);
    return !ill && (a - n > TSAT);
  endfunction

  task automatic clear_frame();
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < NCOL; c++) begin
        fv[r][c] = 1000; fr[r][c] = 1000; fi[r][c] = 1'b0;
      end
    for (int c = 0; c < NCOL; c++) begin
      cavg[c] = 1000; cnbr[c] = 1000; cill[c] = 1'b0;
    end
  endtask

  task automatic expect_frame(int nrows, int clus);
    bit def_prev, def_c;
    int cnt;
    e_pts = 0; e_cols = 0; e_sat = 0; e_adj = 0; def_prev = 0;
    for (int c = 0; c < NCOL; c++) begin
      cnt = 0;
      for (int r = 0; r < nrows; r++)
        if (pt_def(fv[r][c], fr[r][c], fi[r][c])) begin cnt++; e_pts++; end
      def_c = (cnt > 10) || c_offs(cavg[c], cnbr[c], cill[c]) || c_sat(cavg[c], cnbr[c], cill[c]);
      if (c_sat(cavg[c], cnbr[c], cill[c])) e_sat++;
      if (def_c) e_cols++;
      if (def_c && def_prev) e_adj = 1;
      def_prev = def_c;
    end
    e_p1 = (e_pts <= PTL) && (clus <= 40) && (e_cols == 0) && (e_sat == 0) && !e_adj;
    e_p2 = (e_pts <= PTL) && (clus <= 40) && (e_cols <= 15) && (e_sat == 0) && !e_adj;
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic send_pix(int v, int r, bit ill, int col, bit sof, bit eof, bit with_cs);
    pix_valid = 1; pix_value = DW'(v); pix_ref = DW'(r); pix_illum = ill;
    pix_col = CW'(col); pix_sof = sof; pix_eof = eof;
    cst_valid = with_cs; cst_col = CW'(col); cst_avg = DW'(cavg[col]);
    cst_nbr = DW'(cnbr[col]); cst_illum = cill[col];
    while (!pix_ready) begin saw_stall = 1; @(negedge clk); end
    @(negedge clk);
    chk("R3", "flag_valid", int'(flag_valid), 1);
    chk("R3", "flag_col", int'(flag_col), col);
    chk(ill ? "R2" : "R1", "flag_defect", int'(flag_defect), int'(pt_def(v, r, ill)));
    pix_valid = 0; pix_sof = 0; pix_eof = 0; cst_valid = 0;
  endtask

  task automatic check_res(string req);
    chk(req, "res_points", int'(res_points), e_pts);
    chk(req, "res_columns", int'(res_columns), e_cols);
    chk(req, "res_saturated", int'(res_saturated), e_sat);
    chk(req, "res_adjacent", int'(res_adjacent), int'(e_adj));
    chk(req, "res_pass1", int'(res_pass1), int'(e_p1));
    chk(req, "res_pass2", int'(res_pass2), int'(e_p2));
  endtask

  task automatic run_frame(int nrows, int clus, bit wait_res, bit stray, string req);
    expect_frame(nrows, clus);
    ext_clusters = CLW'(clus);
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < NCOL; c++)
        send_pix(fv[r][c], fr[r][c], fi[r][c], c, (r == 0 && c == 0),
                 (r == nrows - 1 && c == NCOL - 1), (r == 0));
    if (stray) begin
      cst_valid = 1; cst_col = CW'(NCOL - 1); cst_illum = 0;
      cst_nbr = DW'(1000); cst_avg = DW'(1100);
    end
    if (wait_res) begin
      while (!res_valid) @(negedge clk);
      cst_valid = 0;
      check_res(req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hold_pts;
    void'($urandom(32'd2024));
    rst_n = 0; pix_valid = 0; pix_sof = 0; pix_eof = 0; pix_col = '0; pix_illum = 0;
    pix_value = '0; pix_ref = '0; cst_valid = 0; cst_col = '0; cst_illum = 0;
    cst_avg = '0; cst_nbr = '0; ext_clusters = '0; saw_stall = 0;
    repeat (3) @(negedge clk);
    chk("R11", "reset pix_ready", int'(pix_ready), 1);
    chk("R10", "reset res_valid", int'(res_valid), 0);
    chk("R3", "reset flag_valid", int'(flag_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 dark boundaries
    clear_frame();
    fv[0][0] = 1000 + TPT; fv[0][1] = 1000 + TPT + 1; fv[0][2] = 100;
    run_frame(1, 0, 1, 0, "R1");
    chk("R1", "dark points", int'(res_points), 1);

    // R2 illuminated boundaries
    clear_frame();
    for (int c = 0; c < NCOL; c++) begin fr[0][c] = 100; fv[0][c] = 100; fi[0][c] = 1; end
    fv[0][0] = 107; fv[0][1] = 108; fv[0][2] = 89; fv[0][3] = 88;
    run_frame(1, 0, 1, 0, "R2");
    chk("R2", "illum points", int'(res_points), 2);

    // R4 promotion: 10 flagged keep class 1, 11 promote
    clear_frame();
    for (int r = 0; r < 10; r++) fv[r][5] = 1100;
    run_frame(11, 0, 1, 0, "R4");
    chk("R4", "ten flagged pass1", int'(res_pass1), 1);
    clear_frame();
    for (int r = 0; r < 11; r++) fv[r][5] = 1100;
    run_frame(11, 0, 1, 0, "R4");
    chk("R4", "eleven flagged columns", int'(res_columns), 1);
    chk("R9", "one column pass2", int'(res_pass2), 1);

    // R5 column offset boundaries
    clear_frame();
    cavg[3] = 1000 + TCOL + 1; cavg[7] = 1000 - TCOL;
    cill[10] = 1; cavg[10] = 1015; cill[11] = 1; cavg[11] = 1016;
    cill[12] = 1; cavg[12] = 985;  cill[13] = 1; cavg[13] = 984;
    run_frame(2, 0, 1, 0, "R5");
    chk("R5", "offset columns", int'(res_columns), 3);

    // R6 saturated
    clear_frame();
    cavg[20] = 1000 + TSAT + 1; cavg[25] = 1000 + TSAT;
    run_frame(2, 0, 1, 0, "R6");
    chk("R6", "saturated count", int'(res_saturated), 1);
    chk("R6", "pass2 low", int'(res_pass2), 0);

    // R7 adjacent
    clear_frame();
    cavg[8] = 1020; cavg[9] = 1020;
    run_frame(2, 0, 1, 0, "R7");
    chk("R7", "adjacent flag", int'(res_adjacent), 1);

    // R9 column limit 15 vs 16
    clear_frame();
    for (int c = 0; c < 30; c += 2) cavg[c] = 1020;
    run_frame(1, 0, 1, 0, "R9");
    chk("R9", "fifteen columns pass2", int'(res_pass2), 1);
    cavg[30] = 1020;
    run_frame(1, 0, 1, 0, "R9");
    chk("R9", "sixteen columns pass2", int'(res_pass2), 0);

    // R8 cluster and point limits
    clear_frame();
    run_frame(1, 40, 1, 0, "R8");
    chk("R8", "40 clusters pass1", int'(res_pass1), 1);
    run_frame(1, 41, 1, 0, "R8");
    chk("R8", "41 clusters pass2", int'(res_pass2), 0);
    clear_frame();
    for (int r = 0; r < 10; r++) for (int c = 0; c < 10; c++) fv[r][c] = 1200;
    run_frame(10, 0, 1, 0, "R8");
    chk("R8", "points at limit pass1", int'(res_pass1), 1);
    fv[0][12] = 1200;
    run_frame(10, 0, 1, 0, "R8");
    chk("R8", "points over limit pass2", int'(res_pass2), 0);

    // R10 hold, out-of-frame sample ignored
    hold_pts = int'(res_points);
    repeat (20) @(negedge clk);
    chk("R10", "hold valid", int'(res_valid), 1);
    chk("R10", "hold points", int'(res_points), hold_pts);
    send_pix(3000, 100, 0, 4, 0, 0, 1);
    chk("R10", "out-of-frame valid", int'(res_valid), 1);
    chk("R10", "out-of-frame points", int'(res_points), hold_pts);

    // R12 stray column statistic during sweep
    clear_frame();
    run_frame(2, 0, 1, 1, "R12");
    chk("R12", "stray ignored pass1", int'(res_pass1), 1);

    // R11 back-to-back frames: first sample of frame B stalls during sweep
    clear_frame();
    fv[0][6] = 1500;
    run_frame(2, 0, 0, 0, "R11");
    clear_frame();
    fv[1][9] = 1500; fv[0][0] = 1500;
    saw_stall = 0;
    run_frame(2, 0, 1, 0, "R11");
    chk("R11", "stall seen", int'(saw_stall), 1);

    // random frames
    for (int k = 0; k < 6; k++) begin
      int nr;
      clear_frame();
      nr = 4 + int'($urandom % 8);
      for (int r = 0; r < nr; r++)
        for (int c = 0; c < NCOL; c++) begin
          fr[r][c] = 200 + int'($urandom % 3000);
          fi[r][c] = $urandom % 2;
          if ($urandom % 5 == 0) fv[r][c] = fr[r][c] - 200 + int'($urandom % 400);
          else fv[r][c] = fr[r][c] - 10 + int'($urandom % 20);
        end
      for (int c = 0; c < NCOL; c++) begin
        cnbr[c] = 1000 + int'($urandom % 1000);
        cill[c] = $urandom % 2;
        if ($urandom % 10 < 8) cavg[c] = cnbr[c] - 5 + int'($urandom % 10);
        else cavg[c] = cnbr[c] - 400 + int'($urandom % 800);
      end
      run_frame(nr, int'($urandom % 45), 1, 0, "R8");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule